// File: doc/BRIEF.md
# Converter Serial Port with Partial-Transfer Recovery

This block is the device-side serial slave of a data converter. A host drives a chip select, a serial clock and a data line into the device and reads a data line back. Through this port the host either drains conversion results from a result FIFO or writes one configuration register. Each FIFO entry is a 16-bit word of four leading bits (normally zero) and twelve result bits, shifted out most significant bit first as two bytes. A register write is a command byte followed by a data byte, both taken most significant bit first.

The block defines what happens when chip select is released in the middle of a byte or a word. A read cut short inside the first byte of an entry is resumed on the next select and gives the next eight bits of that same entry, after which the entry is dropped. A read cut short anywhere after the first byte drops the entry. Later entries always start cleanly. A write cut short updates only the data bits already received, which are passed to the register file with a bit mask so the register keeps its lower bits. Selecting the device while a conversion is still running abandons that conversion and raises a sticky FIFO-corrupt flag.

The serial pins are brought into the block's clock domain through synchronizers and sampled on their edges. The block therefore assumes a system clock several times faster than the serial clock. The FIFO is a show-ahead queue whose head word is valid one clock after a pop.

Top module: `adc_spi_port`

## Requirements
- R1: After reset, `dout`, `fifo_pop`, `reg_wr_en`, `conv_abort` and `fifo_corrupt` are all low.
- R2: The `din` value taken at the first serial clock rising edge after chip select falls selects the transfer: 1 is a register write and 0 is a FIFO read. In a read, all later `din` values are ignored and never cause a register write.
- R3: In a read, `dout` presents the head entry's bit 15 after chip select falls. It moves to the next lower bit after each rising edge, and the host samples it on the rising edge. After the 16th bit of an entry, `fifo_pop` pulses and the next entry follows from its bit 15 in the same transfer.
- R4: If chip select rises after k (1 to 7) bits of an entry's first byte, nothing is popped. The next read transfer returns entry bits 15-k down to 8-k. The entry is popped after those 8 bits, or when chip select rises after at least one of them.
- R5: If chip select rises after the first byte of an entry is complete but before its 16th bit, including exactly 8 bits, the entry is popped and its remaining bits are lost.
- R6: After any cut-short read, the next FIFO entry is read from its bit 15 on the next read transfer, with no bit lost.
- R7: A read transfer with no serial clock edge leaves the FIFO and the entry position unchanged.
- R8: While the FIFO is empty, a read returns zeros on `dout` and `fifo_pop` stays low.
- R9: In a write, transfer bits 2 to 4 give the register address (most significant bit first) and bits 9 to 16 the data. After the 16th bit, `reg_wr_en` pulses once with mask 0xFF. Further clocks in the same transfer are ignored.
- R10: A write cut short after k (1 to 7) data bits pulses `reg_wr_en` once when chip select rises. The mask has its top k bits set, the data carries the received bits in its top k positions, and its lower bits are zero. With k = 0 there is no write.
- R11: Chip select falling while `conv_busy` is high gives a one-cycle `conv_abort` pulse and sets `fifo_corrupt`, which stays set until reset. Chip select falling with `conv_busy` low does neither.
- R12: `fifo_pop` is a single-cycle pulse and never occurs while `fifo_empty` is high. A write transfer never pops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk | input | 1 | Serial clock from host (asynchronous) |
| cs_n | input | 1 | Active-low chip select from host (asynchronous) |
| din | input | 1 | Serial data from host |
| dout | output | 1 | Serial data to host |
| fifo_rd_data | input | 16 | Head entry of the result FIFO (show-ahead) |
| fifo_empty | input | 1 | FIFO holds no entry |
| fifo_pop | output | 1 | Remove the head entry |
| reg_wr_en | output | 1 | Register write strobe |
| reg_wr_addr | output | 3 | Register address |
| reg_wr_data | output | 8 | Register write data |
| reg_wr_mask | output | 8 | Bits of the register to update |
| conv_busy | input | 1 | High while a conversion runs; its fall marks end of conversion |
| conv_abort | output | 1 | Pulse: running conversion abandoned |
| fifo_corrupt | output | 1 | Sticky flag: a conversion was cut off by a select |

## Verification
The bench uses the default parameters: 8-bit bytes, 16-bit entries, a 3-bit register address and two synchronizer stages. With these, each cut-short position can be reached with a handful of serial clocks: a resumed first byte, an exactly-complete first byte, a cut-short second byte, a partial data byte of a write and an empty write. A slow serial clock (six system clocks per half period) keeps the synchronizer and pop latency inside one serial half period. This lets the bench check resumed bits and FIFO drain order directly against its own queue model.

// File: rtl/adc_spi_pkg.sv
// Shared types for the converter serial port.
package adc_spi_pkg;
    // Kind of the current chip-select transfer, fixed by its first bit.
    typedef enum logic [1:0] {
        MODE_IDLE  = 2'd0,
        MODE_READ  = 2'd1,
        MODE_WRITE = 2'd2
    } xfer_mode_e;
endpackage

// File: rtl/adc_spi_sync.sv
// Multi-bit, multi-stage synchronizer for the asynchronous serial pins.
// Assumes each bit is an independent level; no bus coherence is implied.
module adc_spi_sync #(
    parameter int           W           = 3,
    parameter int           STAGES      = 2,
    parameter logic [W-1:0] RST_VAL     = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    // Shift the pin values through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
        end else begin
            stage_q[0] <= d;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/adc_spi_rdeng.sv
// Read engine: tracks the bit position inside the head FIFO entry and applies
// the cut-short rules when chip select rises. Assumes step and fin never
// arrive in the same cycle and that the FIFO head is valid one clock after a pop.
module adc_spi_rdeng #(
    parameter int BYTE_W  = 8,
    localparam int ENTRY_W = 2 * BYTE_W,
    localparam int PTR_W   = $clog2(ENTRY_W),
    localparam int CNT_W   = $clog2(BYTE_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,       // one serial bit consumed in a read
    input  logic             fin,        // chip select released after a read
    input  logic             fifo_empty,
    output logic [PTR_W-1:0] rd_ptr,     // next bit, 0 = entry MSB
    output logic             fifo_pop
);
    localparam logic [PTR_W-1:0] PTR_HALF = PTR_W'(BYTE_W);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(ENTRY_W - 1);
    localparam logic [CNT_W-1:0] SESS_END = CNT_W'(BYTE_W - 1);

    logic [PTR_W-1:0] ptr_q;
    logic [CNT_W-1:0] sess_q;     // bits taken from a resumed entry this transfer
    logic             resumed_q;  // entry's first byte was cut short earlier

    // Advance through the entry, pop on completion or on a discarding release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q     <= '0;
            sess_q    <= '0;
            resumed_q <= 1'b0;
            fifo_pop  <= 1'b0;
        end else begin
            fifo_pop <= 1'b0;
            if (fin) begin
                sess_q <= '0;
                if (!fifo_empty) begin
                    if (resumed_q) begin
                        if (sess_q != '0) begin
                            fifo_pop  <= 1'b1;
                            ptr_q     <= '0;
                            resumed_q <= 1'b0;
                        end
                    end else if (ptr_q >= PTR_HALF) begin
                        fifo_pop <= 1'b1;
                        ptr_q    <= '0;
                    end else if (ptr_q != '0) begin
                        resumed_q <= 1'b1;
                    end
                end
            end else if (step && !fifo_empty) begin
                if (resumed_q) begin
                    if (sess_q == SESS_END) begin
                        fifo_pop  <= 1'b1;
                        ptr_q     <= '0;
                        sess_q    <= '0;
                        resumed_q <= 1'b0;
                    end else begin
                        sess_q <= sess_q + 1'b1;
                        ptr_q  <= ptr_q + 1'b1;
                    end
                end else if (ptr_q == PTR_LAST) begin
                    fifo_pop <= 1'b1;
                    ptr_q    <= '0;
                end else begin
                    ptr_q <= ptr_q + 1'b1;
                end
            end
        end
    end

    assign rd_ptr = ptr_q;
endmodule

// File: rtl/adc_spi_wreng.sv
// Write engine: collects the address and data byte of a register write and
// issues a masked write on completion or on an early chip-select release.
// Assumes ADDR_W < BYTE_W so the address fits in the command byte after the
// mode bit.
module adc_spi_wreng #(
    parameter int BYTE_W  = 8,
    parameter int ADDR_W  = 3,
    localparam int ENTRY_W = 2 * BYTE_W,
    localparam int BC_W    = $clog2(ENTRY_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,      // chip select fell
    input  logic              step,       // one serial bit taken in a write
    input  logic              fin,        // chip select released after a write
    input  logic [BC_W-1:0]   bitcnt,     // bits taken before this one
    input  logic              din,
    output logic              reg_wr_en,
    output logic [ADDR_W-1:0] reg_wr_addr,
    output logic [BYTE_W-1:0] reg_wr_data,
    output logic [BYTE_W-1:0] reg_wr_mask
);
    localparam logic [BYTE_W-1:0] TOP_BIT = {1'b1, {(BYTE_W-1){1'b0}}};
    localparam logic [BC_W-1:0]   ADDR_LO = BC_W'(1);
    localparam logic [BC_W-1:0]   ADDR_HI = BC_W'(ADDR_W);
    localparam logic [BC_W-1:0]   DATA_LO = BC_W'(BYTE_W);
    localparam logic [BC_W-1:0]   DATA_LT = BC_W'(ENTRY_W);
    localparam logic [BC_W-1:0]   DATA_LS = BC_W'(ENTRY_W - 1);

    logic [ADDR_W-1:0] addr_q;
    logic [BYTE_W-1:0] data_q, mask_q;
    logic              in_addr, in_data;
    logic [BC_W-1:0]   didx;
    logic [BYTE_W-1:0] sel, data_nxt, mask_nxt;

    // Place the incoming data bit, MSB first, and grow the mask behind it.
    always_comb begin
        in_addr  = (bitcnt >= ADDR_LO) && (bitcnt <= ADDR_HI);
        in_data  = (bitcnt >= DATA_LO) && (bitcnt < DATA_LT);
        didx     = bitcnt - DATA_LO;
        sel      = in_data ? (TOP_BIT >> didx) : '0;
        mask_nxt = mask_q | sel;
        data_nxt = din ? (data_q | sel) : data_q;
    end

    // Collect bits and launch the full or partial register write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q      <= '0;
            data_q      <= '0;
            mask_q      <= '0;
            reg_wr_en   <= 1'b0;
            reg_wr_addr <= '0;
            reg_wr_data <= '0;
            reg_wr_mask <= '0;
        end else begin
            reg_wr_en <= 1'b0;
            if (start) begin
                addr_q <= '0;
                data_q <= '0;
                mask_q <= '0;
            end else if (step) begin
                if (in_addr) addr_q <= ADDR_W'({addr_q, din});
                data_q <= data_nxt;
                mask_q <= mask_nxt;
                if (bitcnt == DATA_LS) begin
                    reg_wr_en   <= 1'b1;
                    reg_wr_addr <= addr_q;
                    reg_wr_data <= data_nxt;
                    reg_wr_mask <= mask_nxt;
                end
            end else if (fin && (mask_q != '0) && (mask_q != '1)) begin
                reg_wr_en   <= 1'b1;
                reg_wr_addr <= addr_q;
                reg_wr_data <= data_q;
                reg_wr_mask <= mask_q;
            end
        end
    end
endmodule

// File: rtl/adc_spi_port.sv
// Converter serial port top: synchronizes the serial pins, detects their
// edges, picks the transfer kind from the first bit and routes bits to the
// read and write engines. Drives dout from the FIFO head at the read position.
// Assumes clk runs several times faster than sclk and that the host changes
// din while sclk is low and samples dout on the sclk rising edge.
module adc_spi_port
    import adc_spi_pkg::*;
#(
    parameter int BYTE_W      = 8,
    parameter int ADDR_W      = 3,
    parameter int SYNC_STAGES = 2,
    localparam int ENTRY_W    = 2 * BYTE_W,
    localparam int PTR_W      = $clog2(ENTRY_W),
    localparam int BC_W       = $clog2(ENTRY_W + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sclk,
    input  logic               cs_n,
    input  logic               din,
    output logic               dout,
    input  logic [ENTRY_W-1:0] fifo_rd_data,
    input  logic               fifo_empty,
    output logic               fifo_pop,
    output logic               reg_wr_en,
    output logic [ADDR_W-1:0]  reg_wr_addr,
    output logic [BYTE_W-1:0]  reg_wr_data,
    output logic [BYTE_W-1:0]  reg_wr_mask,
    input  logic               conv_busy,
    output logic               conv_abort,
    output logic               fifo_corrupt
);
    localparam logic [BC_W-1:0] BC_MAX = BC_W'(ENTRY_W);

    logic [2:0]        pins_s;
    logic              sclk_s, csn_s, din_s;
    logic              sclk_d, csn_d;
    logic              sclk_rise, cs_fall, cs_rise, active;
    logic [BC_W-1:0]   bitcnt_q;
    xfer_mode_e        mode_q;
    logic              first_bit, rd_step, wr_step, rd_fin, wr_fin;
    logic [PTR_W-1:0]  rd_ptr;
    logic [ENTRY_W-1:0] head_shift;

    adc_spi_sync #(
        .W       (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b010)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({sclk, cs_n, din}),
        .q     (pins_s)
    );

    assign sclk_s = pins_s[2];
    assign csn_s  = pins_s[1];
    assign din_s  = pins_s[0];

    // Remember the previous synchronized levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_d <= 1'b0;
            csn_d  <= 1'b1;
        end else begin
            sclk_d <= sclk_s;
            csn_d  <= csn_s;
        end
    end

    assign active    = !csn_s;
    assign sclk_rise = sclk_s && !sclk_d && active;
    assign cs_fall   = csn_d && !csn_s;
    assign cs_rise   = !csn_d && csn_s;
    assign first_bit = sclk_rise && (bitcnt_q == '0);
    assign rd_step   = sclk_rise && ((mode_q == MODE_READ)  || (first_bit && !din_s));
    assign wr_step   = sclk_rise && ((mode_q == MODE_WRITE) || (first_bit &&  din_s));
    assign rd_fin    = cs_rise && (mode_q == MODE_READ);
    assign wr_fin    = cs_rise && (mode_q == MODE_WRITE);

    // Count bits of the transfer (saturating) and latch its kind.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bitcnt_q <= '0;
            mode_q   <= MODE_IDLE;
        end else if (cs_fall || cs_rise) begin
            bitcnt_q <= '0;
            mode_q   <= MODE_IDLE;
        end else if (sclk_rise) begin
            if (first_bit) mode_q <= din_s ? MODE_WRITE : MODE_READ;
            if (bitcnt_q != BC_MAX) bitcnt_q <= bitcnt_q + 1'b1;
        end
    end

    // Flag a conversion cut off by the host selecting the device too early.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            conv_abort   <= 1'b0;
            fifo_corrupt <= 1'b0;
        end else begin
            conv_abort <= cs_fall && conv_busy;
            if (cs_fall && conv_busy) fifo_corrupt <= 1'b1;
        end
    end

    adc_spi_rdeng #(
        .BYTE_W (BYTE_W)
    ) u_rdeng (
        .clk        (clk),
        .rst_n      (rst_n),
        .step       (rd_step),
        .fin        (rd_fin),
        .fifo_empty (fifo_empty),
        .rd_ptr     (rd_ptr),
        .fifo_pop   (fifo_pop)
    );

    adc_spi_wreng #(
        .BYTE_W (BYTE_W),
        .ADDR_W (ADDR_W)
    ) u_wreng (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (cs_fall),
        .step        (wr_step),
        .fin         (wr_fin),
        .bitcnt      (bitcnt_q),
        .din         (din_s),
        .reg_wr_en   (reg_wr_en),
        .reg_wr_addr (reg_wr_addr),
        .reg_wr_data (reg_wr_data),
        .reg_wr_mask (reg_wr_mask)
    );

    // Present the head entry's bit at the read position, zero otherwise.
    assign head_shift = fifo_rd_data << rd_ptr;
    assign dout = active && (mode_q != MODE_WRITE) && !fifo_empty
                  && head_shift[ENTRY_W-1];
endmodule

// File: rtl/adc_spi_port_chk.sv
// Port-level property checker for adc_spi_port, attached with bind.
module adc_spi_port_chk #(
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fifo_empty,
    input logic              fifo_pop,
    input logic              reg_wr_en,
    input logic [BYTE_W-1:0] reg_wr_data,
    input logic [BYTE_W-1:0] reg_wr_mask,
    input logic              conv_abort,
    input logic              fifo_corrupt
);
    logic [BYTE_W-1:0] inv_mask, inv_mask_p1;
    assign inv_mask    = ~reg_wr_mask;
    assign inv_mask_p1 = inv_mask + BYTE_W'(1);

    assert_pop_not_empty_R12: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> !fifo_empty);

    assert_pop_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |=> !fifo_pop);

    assert_wr_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |=> !reg_wr_en);

    assert_mask_from_msb_R10: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |-> ((reg_wr_mask != '0) && ((inv_mask & inv_mask_p1) == '0)));

    assert_data_in_mask_R10: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |-> ((reg_wr_data & inv_mask) == '0));

    assert_abort_flags_R11: assert property (@(posedge clk) disable iff (!rst_n)
        conv_abort |-> fifo_corrupt);

    assert_corrupt_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_corrupt |=> fifo_corrupt);
endmodule

bind adc_spi_port adc_spi_port_chk #(.BYTE_W(BYTE_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .fifo_empty   (fifo_empty),
    .fifo_pop     (fifo_pop),
    .reg_wr_en    (reg_wr_en),
    .reg_wr_data  (reg_wr_data),
    .reg_wr_mask  (reg_wr_mask),
    .conv_abort   (conv_abort),
    .fifo_corrupt (fifo_corrupt)
);

// File: tb/tb_adc_spi_port.sv
// Directed bench: a queue model stands in for the FIFO, a monitor records
// register writes, and one task per scenario checks its own results.
module tb_adc_spi_port;
    localparam int H = 6;  // system clocks per serial half period

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b0, cs_n = 1'b1, din = 1'b0, conv_busy = 1'b0;
    logic        dout, fifo_pop, reg_wr_en, conv_abort, fifo_corrupt;
    logic [15:0] fifo_rd_data;
    logic        fifo_empty;
    logic [2:0]  reg_wr_addr;
    logic [7:0]  reg_wr_data, reg_wr_mask;

    int          n_tests = 0, n_fail = 0;
    int          pops = 0, wrs = 0, aborts = 0;
    logic [2:0]  last_addr;
    logic [7:0]  last_data, last_mask;
    logic [15:0] fq [0:15];
    int          head = 0, tail = 0;
    bit          done = 0;

    always #2 clk = ~clk;

    adc_spi_port dut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .din(din),
        .dout(dout), .fifo_rd_data(fifo_rd_data), .fifo_empty(fifo_empty),
        .fifo_pop(fifo_pop), .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr),
        .reg_wr_data(reg_wr_data), .reg_wr_mask(reg_wr_mask),
        .conv_busy(conv_busy), .conv_abort(conv_abort), .fifo_corrupt(fifo_corrupt)
    );

    assign fifo_empty   = (head == tail);
    assign fifo_rd_data = fifo_empty ? 16'h0 : fq[head[3:0]];

    // FIFO model, write and abort monitors.
    always @(posedge clk) begin
        if (fifo_pop && head != tail) head <= head + 1;
        if (fifo_pop) pops <= pops + 1;
        if (reg_wr_en) begin
            wrs <= wrs + 1; last_addr <= reg_wr_addr;
            last_data <= reg_wr_data; last_mask <= reg_wr_mask;
        end
        if (conv_abort) aborts <= aborts + 1;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push(input logic [15:0] w);
        fq[tail[3:0]] = w;
        tail++;
    endtask

    // One chip-select transfer of n clocks; din bits and dout bits MSB-aligned.
    task automatic xfer(input int n, input logic [31:0] dv, output logic [31:0] got);
        got = '0;
        cs_n = 1'b0;
        wclk(H);
        for (int i = 0; i < n; i++) begin
            din = dv[31-i];
            wclk(H);
            got[31-i] = dout;
            sclk = 1'b1;
            wclk(H);
            sclk = 1'b0;
        end
        wclk(H);
        cs_n = 1'b1;
        din  = 1'b0;
        wclk(3 * H);
    endtask

    function automatic logic [31:0] expb(input logic [15:0] w, input int st, input int n);
        logic [31:0] r = '0;
        for (int i = 0; i < n; i++) r[31-i] = w[15-st-i];
        return r;
    endfunction

    function automatic logic [31:0] topn(input logic [31:0] v, input int n);
        return (n == 0) ? 32'h0 : (v & ~(32'hFFFF_FFFF >> n));
    endfunction

    task automatic t_reset;
        chk(dout == 0 && fifo_pop == 0, "R1 dout/pop", {dout, fifo_pop}, 0);
        chk(reg_wr_en == 0 && conv_abort == 0 && fifo_corrupt == 0, "R1 flags",
            {reg_wr_en, conv_abort, fifo_corrupt}, 0);
    endtask

    task automatic t_full_read;
        logic [31:0] g;
        int p0 = pops, w0 = wrs;
        push(16'h0ABC); push(16'h0123);
        xfer(32, 32'h7FFF_FFFF, g);  // first bit 0, then ones: still a read
        chk(g == {16'h0ABC, 16'h0123}, "R3 two entries in one transfer", g, {16'h0ABC, 16'h0123});
        chk(pops - p0 == 2, "R3 pop count", pops - p0, 2);
        chk(wrs == w0, "R2 din ignored in read", wrs - w0, 0);
    endtask

    task automatic t_cut_first;
        logic [31:0] g;
        int p0 = pops;
        push(16'h0F5A); push(16'h0C3E);
        xfer(3, 32'h0, g);
        chk(g == expb(16'h0F5A, 0, 3), "R4 first 3 bits", g, expb(16'h0F5A, 0, 3));
        chk(pops == p0, "R4 no pop after cut first byte", pops - p0, 0);
        xfer(8, 32'h0, g);
        chk(g == expb(16'h0F5A, 3, 8), "R4 resumed bits 12..5", g, expb(16'h0F5A, 3, 8));
        chk(pops - p0 == 1, "R4 pop after resumed byte", pops - p0, 1);
        xfer(16, 32'h0, g);
        chk(g == {16'h0C3E, 16'h0}, "R6 next entry intact", g, {16'h0C3E, 16'h0});
        // resumed byte itself cut short: entry dropped
        push(16'h0777); push(16'h0246);
        p0 = pops;
        xfer(5, 32'h0, g);
        xfer(2, 32'h0, g);
        chk(g == expb(16'h0777, 5, 2), "R4 resumed bits cut", g, expb(16'h0777, 5, 2));
        chk(pops - p0 == 1, "R4 cut resumed byte pops", pops - p0, 1);
        xfer(16, 32'h0, g);
        chk(g == {16'h0246, 16'h0}, "R6 entry after cut resume", g, {16'h0246, 16'h0});
    endtask

    task automatic t_cut_second;
        logic [31:0] g;
        int p0 = pops;
        push(16'h0ABC); push(16'h0123);
        xfer(12, 32'h0, g);
        chk(g == topn({16'h0ABC, 16'h0}, 12), "R5 12 bits", g, topn({16'h0ABC, 16'h0}, 12));
        chk(pops - p0 == 1, "R5 pop on second-byte cut", pops - p0, 1);
        xfer(16, 32'h0, g);
        chk(g == {16'h0123, 16'h0}, "R6 after second-byte cut", g, {16'h0123, 16'h0});
        push(16'h0E01); push(16'h0D55);
        p0 = pops;
        xfer(8, 32'h0, g);
        chk(pops - p0 == 1, "R5 exactly 8 bits discards", pops - p0, 1);
        xfer(16, 32'h0, g);
        chk(g == {16'h0D55, 16'h0}, "R6 after 8-bit cut", g, {16'h0D55, 16'h0});
    endtask

    task automatic t_no_clock;
        logic [31:0] g;
        int p0 = pops;
        push(16'h0B0B);
        xfer(0, 32'h0, g);
        chk(pops == p0, "R7 no pop without clocks", pops - p0, 0);
        xfer(16, 32'h0, g);
        chk(g == {16'h0B0B, 16'h0}, "R7 entry unchanged", g, {16'h0B0B, 16'h0});
    endtask

    task automatic t_empty;
        logic [31:0] g;
        int p0 = pops;
        xfer(16, 32'h0, g);
        chk(g == 0, "R8 zeros from empty FIFO", g, 0);
        chk(pops == p0, "R8 no pop when empty", pops - p0, 0);
    endtask

    task automatic t_writes;
        logic [31:0] g;
        int w0, p0;
        push(16'h0FED);  // must survive the writes
        p0 = pops;
        w0 = wrs;
        xfer(16, 32'hD0A5_0000, g);  // 1,addr 101,0000,data A5
        chk(wrs - w0 == 1, "R9 one full write", wrs - w0, 1);
        chk({last_addr, last_data, last_mask} == {3'd5, 8'hA5, 8'hFF}, "R9 full write fields",
            {last_addr, last_data, last_mask}, {3'd5, 8'hA5, 8'hFF});
        w0 = wrs;
        xfer(20, 32'hD05A_F000, g);  // extra clocks after 16
        chk(wrs - w0 == 1 && last_data == 8'h5A, "R9 extra clocks ignored", wrs - w0, 1);
        w0 = wrs;
        xfer(11, 32'hA0C0_0000, g);  // addr 010, three data bits 110
        chk(wrs - w0 == 1, "R10 partial write issued", wrs - w0, 1);
        chk({last_addr, last_data, last_mask} == {3'd2, 8'hC0, 8'hE0}, "R10 partial fields",
            {last_addr, last_data, last_mask}, {3'd2, 8'hC0, 8'hE0});
        w0 = wrs;
        xfer(8, 32'hD000_0000, g);
        chk(wrs == w0, "R10 no write with zero data bits", wrs - w0, 0);
        chk(pops == p0, "R12 writes never pop", pops - p0, 0);
        xfer(16, 32'h0, g);
        chk(g == {16'h0FED, 16'h0}, "R12 entry kept across writes", g, {16'h0FED, 16'h0});
    endtask

    task automatic t_abort;
        logic [31:0] g;
        chk(aborts == 0 && fifo_corrupt == 0, "R11 idle conv no abort", aborts, 0);
        conv_busy = 1'b1;
        xfer(0, 32'h0, g);
        conv_busy = 1'b0;
        chk(aborts == 1, "R11 one abort pulse", aborts, 1);
        chk(fifo_corrupt == 1, "R11 corrupt set", fifo_corrupt, 1);
        xfer(4, 32'h0, g);
        chk(fifo_corrupt == 1 && aborts == 1, "R11 corrupt sticky", {aborts, fifo_corrupt}, {1, 1});
    endtask

    initial begin
        wclk(5);
        rst_n = 1'b1;
        wclk(5);
        t_reset();
        t_full_read();
        t_cut_first();
        t_cut_second();
        t_no_clock();
        t_empty();
        t_writes();
        t_abort();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule